// File: doc/BRIEF.md
# Interleaved Quad-SPI Trace Writer

This block records a stream of target bus samples into serial SRAM devices driven over 4-bit-wide SPI links. The links need no external address counters. Each sample is one data byte plus a control nibble. The byte is split by nibble, and the low and high halves go to two devices that are written in lockstep. A third device in the same bank stores the control nibble. Each device holds 1 Mbit, so a bank of three devices stores 256K samples at one nibble per device per sample.

There are two banks, and they take samples in turn: sample 0, 2, 4 and so on go to bank 0, and sample 1, 3, 5 and so on go to bank 1. This doubles the sample rate past what one serial clock can carry and gives 512K samples in total. A start command opens both banks with one sequential quad write and the 24-bit address zero. Samples then stream without any further addressing. A stop command closes the capture. Each bank raises its chip select once it has finished its last nibble.

Samples enter on a valid/ready handshake. A sample moves on a cycle where `smp_valid` and `smp_ready` are both high. While `smp_valid` is high and `smp_ready` is low, the source must hold `smp_data` and `smp_ctrl` steady. `smp_ready` stays low outside streaming. Once both banks stream, the block accepts one sample every clock.

Top module: `quad_trace_writer`

## Requirements
- R1: After reset both chip selects are high, both serial clocks are low, all bank data lines are 0 and `smp_ready` is 0.
- R2: A start taken while both banks are idle lowers both chip selects. Each bank then sends eight header nibbles on every one of its three device lanes, most significant first: 0x0, 0x2, then six 0x0 (write command 0x02 followed by the address 0x000000).
- R3: Each sample is written as one nibble per device. Bank data bits [3:0] carry `smp_data[3:0]`, bits [7:4] carry `smp_data[7:4]`, and bits [11:8] carry `smp_ctrl`.
- R4: Samples are numbered from 0 at each start. Even-numbered samples go to bank 0 and odd-numbered samples go to bank 1. No sample reaches both banks.
- R5: Every nibble is driven for one clock with the serial clock low, then held for one clock with the serial clock high. The device captures on the rising edge. The serial clock is high only while that bank's chip select is low.
- R6: `smp_ready` is high only while streaming and no stop is pending. With `smp_valid` held high, one sample is accepted every clock.
- R7: After the clock in which `stop` is high, no sample is accepted. A sample accepted in that same clock is still written in full. Each chip select rises only after all nibbles owed to its bank have been clocked out. A stop given during the header lets the header finish and then closes the capture.
- R8: A start given while either bank is not idle has no effect: no new header is sent and the sample order goes on. A stop given while both banks are idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture start command (pulse) |
| stop | input | 1 | Capture stop command (pulse) |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Sample taken this clock when valid is high |
| smp_data | input | 8 | Target data byte |
| smp_ctrl | input | 4 | Target control nibble |
| b0_cs_n | output | 1 | Bank 0 chip select, active low |
| b0_sck | output | 1 | Bank 0 serial clock |
| b0_io | output | 12 | Bank 0 lanes: [3:0] low-nibble device, [7:4] high-nibble device, [11:8] control device |
| b1_cs_n | output | 1 | Bank 1 chip select, active low |
| b1_sck | output | 1 | Bank 1 serial clock |
| b1_io | output | 12 | Bank 1 lanes, same layout as bank 0 |

## Verification
A stop can arrive in the same clock as a sample handshake. That sample has to reach its bank before the chip select rises, and nothing may be accepted after it. The bench raises `stop` during a run where `smp_valid` stays high, so the stop clock always carries an accepted sample. A queue model then expects each bank's owed nibbles to drain completely before its chip select goes high. A second overlap puts a start pulse into a live stream. The model expects no new header there and expects the even/odd numbering to go on, so any restart shows up as a nibble mismatch.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int NIB_W   = 4;
  localparam int DEV_N   = 3;
  localparam int IO_W    = NIB_W * DEV_N;
  localparam int DATA_W  = 2 * NIB_W;
  localparam int CTRL_W  = NIB_W;
  localparam int BANKS   = 2;
  localparam int ADDR_W  = 24;
  localparam int CMD_W   = 8;
  localparam logic [CMD_W-1:0] CMD_SEQ_WRITE = 8'h02;
  localparam int HDR_W   = CMD_W + ADDR_W;
  localparam int HDR_N   = HDR_W / NIB_W;
  localparam int CNT_W   = $clog2(HDR_N + 1);

  typedef enum logic [1:0] {LN_IDLE, LN_HDR, LN_STRM} lane_st_t;

  function automatic logic [NIB_W-1:0] hdr_nib(input logic [CNT_W-1:0] idx);
    logic [HDR_W-1:0] word;
    word = {CMD_SEQ_WRITE, {ADDR_W{1'b0}}};
    return word[HDR_W-1 - int'(idx)*NIB_W -: NIB_W];
  endfunction
endpackage

// File: rtl/tw_lane.sv
module tw_lane
  import tw_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic            stop_in,
  input  logic            take,
  input  logic [IO_W-1:0] nibs,
  output logic            ready,
  output logic            cs_n,
  output logic            sck,
  output logic [IO_W-1:0] io
);
  lane_st_t         st;
  logic             busy, ph, stop_pend;
  logic [CNT_W-1:0] cnt;

  assign ready = (st == LN_STRM) && !stop_pend && (!busy || ph);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= LN_IDLE;
      busy      <= 1'b0;
      ph        <= 1'b0;
      sck       <= 1'b0;
      cs_n      <= 1'b1;
      io        <= '0;
      cnt       <= '0;
      stop_pend <= 1'b0;
    end else begin
      if (stop_in && st != LN_IDLE) stop_pend <= 1'b1;
      case (st)
        LN_IDLE: begin
          if (go) begin
            st        <= LN_HDR;
            cs_n      <= 1'b0;
            io        <= {DEV_N{hdr_nib('0)}};
            busy      <= 1'b1;
            ph        <= 1'b0;
            sck       <= 1'b0;
            cnt       <= CNT_W'(1);
            stop_pend <= 1'b0;
          end
        end
        LN_HDR: begin
          if (!ph) begin
            sck <= 1'b1;
            ph  <= 1'b1;
          end else if (cnt == CNT_W'(HDR_N)) begin
            st   <= LN_STRM;
            busy <= 1'b0;
            sck  <= 1'b0;
          end else begin
            io  <= {DEV_N{hdr_nib(cnt)}};
            cnt <= cnt + CNT_W'(1);
            ph  <= 1'b0;
            sck <= 1'b0;
          end
        end
        LN_STRM: begin
          if (take) begin
            io   <= nibs;
            busy <= 1'b1;
            ph   <= 1'b0;
            sck  <= 1'b0;
          end else if (busy && !ph) begin
            sck <= 1'b1;
            ph  <= 1'b1;
          end else begin
            busy <= 1'b0;
            sck  <= 1'b0;
            if (stop_pend) begin
              st        <= LN_IDLE;
              cs_n      <= 1'b1;
              stop_pend <= 1'b0;
            end
          end
        end
        default: st <= LN_IDLE;
      endcase
    end
  end

  AST_SCK_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n) sck |-> !cs_n); // R5
  AST_SCK_ONE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) sck |=> !sck); // R5
  AST_IO_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n) sck |-> $stable(io)); // R5
  AST_NO_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !ready); // R6
endmodule

// File: rtl/tw_steer.sv
module tw_steer
  import tw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             s_valid,
  input  logic [BANKS-1:0] rdy,
  output logic [BANKS-1:0] take,
  output logic             s_ready
);
  localparam int SEL_W = (BANKS > 1) ? $clog2(BANKS) : 1;
  logic [SEL_W-1:0] sel;

  assign s_ready = rdy[sel];

  always_comb begin
    for (int i = 0; i < BANKS; i++)
      take[i] = s_valid && rdy[i] && (sel == SEL_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel <= '0;
    else if (go) sel <= '0;
    else if (s_valid && s_ready)
      sel <= (sel == SEL_W'(BANKS-1)) ? '0 : sel + SEL_W'(1);
  end

  AST_ONE_BANK_TAKES: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(take)); // R4
endmodule

// File: rtl/quad_trace_writer.sv
module quad_trace_writer
  import tw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [DATA_W-1:0] smp_data,
  input  logic [CTRL_W-1:0] smp_ctrl,
  output logic              b0_cs_n,
  output logic              b0_sck,
  output logic [IO_W-1:0]   b0_io,
  output logic              b1_cs_n,
  output logic              b1_sck,
  output logic [IO_W-1:0]   b1_io
);
  logic [BANKS-1:0] rdy, take, csn, sck;
  logic [IO_W-1:0]  io [BANKS];
  logic [IO_W-1:0]  nibs;
  logic             go;

  assign go   = start && (&csn);
  assign nibs = {smp_ctrl, smp_data};

  tw_steer u_steer (
    .clk(clk), .rst_n(rst_n), .go(go), .s_valid(smp_valid),
    .rdy(rdy), .take(take), .s_ready(smp_ready)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    tw_lane u_lane (
      .clk(clk), .rst_n(rst_n), .go(go), .stop_in(stop), .take(take[b]),
      .nibs(nibs), .ready(rdy[b]), .cs_n(csn[b]), .sck(sck[b]), .io(io[b])
    );
  end

  assign b0_cs_n = csn[0];
  assign b0_sck  = sck[0];
  assign b0_io   = io[0];
  assign b1_cs_n = csn[1];
  assign b1_sck  = sck[1];
  assign b1_io   = io[1];

  AST_NO_TAKE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n) stop |=> !smp_ready); // R7
endmodule

// File: tb/quad_trace_writer_tb.sv
module quad_trace_writer_tb;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, stop = 0, smp_valid = 0, smp_ready;
  logic [7:0] smp_data = 0;
  logic [3:0] smp_ctrl = 0;
  logic b0_cs_n, b0_sck, b1_cs_n, b1_sck;
  logic [11:0] b0_io, b1_io;

  int checks = 0, failures = 0;
  logic [12:0] expq0[$], expq1[$];
  int parity = 0, accepted = 0;
  logic pcs0 = 1, pcs1 = 1, psck0 = 0, psck1 = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_trace_writer u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic observe(input int b, input logic cs, input logic sck, input logic [11:0] io,
                         input logic pcs, input logic psck);
    logic [12:0] e;
    if (sck && !psck) begin
      if (b == 0 && expq0.size() > 0) e = expq0.pop_front();
      else if (b == 1 && expq1.size() > 0) e = expq1.pop_front();
      else e = 13'h1FFF;
      if (e == 13'h1FFF) chk(0, "R5 unexpected clock", {31'd0, sck}, 0);
      else chk(io == e[11:0], e[12] ? "R2 header nibble" : "R3 R4 sample nibble", io, e[11:0]);
      chk(!cs, "R5 cs low at rise", cs, 0);
    end
    if (cs && !pcs) chk((b == 0 ? expq0.size() : expq1.size()) == 0, "R7 owed nibbles at cs rise",
                        b == 0 ? expq0.size() : expq1.size(), 0);
  endtask

  task automatic tick(input bit v, input bit st, input bit sp);
    bit idle;
    @(negedge clk);
    observe(0, b0_cs_n, b0_sck, b0_io, pcs0, psck0);
    observe(1, b1_cs_n, b1_sck, b1_io, pcs1, psck1);
    idle = b0_cs_n && b1_cs_n;
    pcs0 = b0_cs_n; pcs1 = b1_cs_n; psck0 = b0_sck; psck1 = b1_sck;
    if (v && !(smp_valid && !smp_ready)) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      smp_data = lfsr[7:0];
      smp_ctrl = lfsr[11:8];
    end
    smp_valid = v; start = st; stop = sp;
    #1;
    if (st && idle) begin
      parity = 0;
      for (int k = 0; k < 8; k++) begin
        expq0.push_back({1'b1, {3{(k == 1) ? 4'h2 : 4'h0}}});
        expq1.push_back({1'b1, {3{(k == 1) ? 4'h2 : 4'h0}}});
      end
    end
    if (smp_valid && smp_ready) begin
      accepted++;
      if (parity == 0) expq0.push_back({1'b0, smp_ctrl, smp_data});
      else expq1.push_back({1'b0, smp_ctrl, smp_data});
      parity ^= 1;
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      tick(0, 0, 0);
      if (b0_cs_n && b1_cs_n && expq0.size() == 0 && expq1.size() == 0) break;
    end
    tick(0, 0, 0);
    chk(b0_cs_n && b1_cs_n, "R7 banks closed", {b1_cs_n, b0_cs_n}, 2'b11);
    chk(expq0.size() + expq1.size() == 0, "R7 all nibbles written", expq0.size() + expq1.size(), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int first, cyc, mark;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(b0_cs_n && b1_cs_n, "R1 cs high", {b1_cs_n, b0_cs_n}, 2'b11);
    chk(!b0_sck && !b1_sck, "R1 sck low", {b1_sck, b0_sck}, 0);
    chk(b0_io == 0 && b1_io == 0, "R1 io zero", {b1_io, b0_io}, 0);
    chk(!smp_ready, "R1 ready low", smp_ready, 0);

    // R8: stop while idle has no effect
    tick(0, 0, 1);
    repeat (3) tick(0, 0, 0);
    chk(b0_cs_n && b1_cs_n && !smp_ready, "R8 stop idle", {b1_cs_n, b0_cs_n}, 2'b11);

    // R2/R6: start, then full-rate stream; stop coincides with a handshake (R7)
    tick(0, 1, 0);
    tick(0, 0, 0);
    chk(!b0_cs_n && !b1_cs_n, "R2 cs low after start", {b1_cs_n, b0_cs_n}, 0);
    accepted = 0; first = -1; cyc = 0;
    while (accepted < 40 && cyc < 200) begin
      tick(1, 0, 0);
      cyc++;
      if (first < 0 && accepted == 1) first = cyc;
    end
    chk(cyc - first == 39, "R6 one sample per clock", cyc - first, 39);
    mark = accepted;
    tick(1, 0, 1);
    chk(accepted == mark + 1, "R7 sample in stop cycle taken", accepted - mark, 1);
    mark = accepted;
    repeat (4) tick(1, 0, 0);
    chk(accepted == mark, "R7 nothing after stop", accepted - mark, 0);
    wait_idle();

    // R8: restart with gaps; start pulse mid-stream ignored
    tick(0, 1, 0);
    for (int i = 0; i < 80; i++) begin
      tick(lfsr[3] | lfsr[9], i == 40, 0);
      if (i == 41) chk(!b0_cs_n && !b1_cs_n, "R8 start mid-stream", {b1_cs_n, b0_cs_n}, 0);
    end
    tick(0, 0, 1);
    wait_idle();

    // R7: stop during header
    tick(0, 1, 0);
    tick(0, 0, 0);
    tick(1, 0, 1);
    mark = accepted;
    for (int i = 0; i < 30; i++) tick(1, 0, 0);
    chk(accepted == mark, "R7 no samples after header stop", accepted - mark, 0);
    wait_idle();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule